// File: doc/BRIEF.md
# Shared Mailbox Register Bank

This block holds a small set of single-word mailboxes that two processors use to pass short messages to each other. Each mailbox is one 32-bit word. Its top bit is the handshake flag that marks the word as holding a message, and the other 31 bits are the message. The sender stores its message with the flag set. The receiver reads the word and then writes it back with the flag cleared, which hands the slot back to the sender.

A single level interrupt output tells either side when a mailbox has changed state. Every mailbox contributes a "holding a message" condition and a "free" condition. An enable register picks which of these conditions may drive the interrupt line. A read-only summary register shows all the conditions at once, and a sizing register reports how many mailboxes the bank was built with.

All access uses a simple register bus with address, write data, write enable, read enable and read data. Read data is registered and arrives one cycle after the read enable.

Top module: `shmbox_bank`

## Requirements
- R1: After reset every mailbox reads 0 and the enable register reads 0. The interrupt output is low. The summary register shows only the free bits of the mailboxes that are built.
- R2: Mailbox i (i below MB_COUNT) sits at byte address 0x10000 + i*0x8000. A write there with bit 31 set stores the whole 32-bit word, and a read there returns that word, so bits 30:0 come back as the message and bit 31 reads 1.
- R3: A write to a mailbox with bit 31 clear stores the word with the flag low, which frees the mailbox. The message bits read back as written.
- R4: The summary register at 0x304 reports, for each built mailbox i, the live flag in bit 8+i and its inverse in bit i. Bits for mailboxes that are not built read 0, bits 31:16 read 0, and writes to this address change nothing.
- R5: The enable register at 0x100 stores the "holding" enables in bits 15:8 (mailbox i at bit 8+i) and the "free" enables in bits 7:0 (mailbox i at bit i). It reads back what was written, except that bits 31:16 and the bits of mailboxes that are not built read 0.
- R6: The interrupt output is the OR, over all 16 bits, of the summary bit ANDed with its enable bit. It is registered: it shows the state as it stood one clock after the write that changed the state. It stays high while the condition lasts.
- R7: The sizing register at 0x380 returns MB_COUNT in bits 3:0 and zero in all other bits.
- R8: A mailbox window at or beyond MB_COUNT, and any address that is not mapped, reads 0. A write to such an address changes no register.
- R9: Read data updates only in the cycle after a read enable and holds its value otherwise.
- R10: When a write and a read hit the same register in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Registered shared interrupt level |

## Verification
The bench builds the bank with MB_COUNT = 6 and ADDR_W = 20. This leaves two decoded mailbox windows, 6 and 7, that are not built. Writes and reads aimed at them, and enable bits written for them, must then have no effect. Random traffic mixes message stores, frees and enable patterns. This lets the interrupt follow both free and holding events, while the full-width enable pattern lights the line from free conditions alone.

// File: rtl/shmbox_pkg.sv
package shmbox_pkg;
  localparam int MB_SLOTS    = 8;
  localparam int WIN_SHIFT   = 15;
  localparam int FIRST_WIN   = 2;
  localparam logic [31:0] OFF_ENABLE = 32'h0000_0100;
  localparam logic [31:0] OFF_STATUS = 32'h0000_0304;
  localparam logic [31:0] OFF_SIZING = 32'h0000_0380;

  // Byte address of mailbox slot i
  function automatic logic [31:0] mb_base(input int i);
    return 32'h0001_0000 + 32'(i) * 32'h0000_8000;
  endfunction

  // One bit per built mailbox
  function automatic logic [MB_SLOTS-1:0] built_mask(input int count);
    logic [MB_SLOTS-1:0] m;
    m = '0;
    for (int i = 0; i < MB_SLOTS; i++)
      if (i < count) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/shmbox_decode.sv
module shmbox_decode
  import shmbox_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int MB_COUNT = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit_enable,
  output logic                hit_status,
  output logic                hit_sizing,
  output logic [MB_SLOTS-1:0] hit_mb
);
  localparam int HI_W = ADDR_W - WIN_SHIFT;

  logic              low_clear;
  logic [HI_W-1:0]   win_no;

  assign low_clear  = (addr[WIN_SHIFT-1:0] == '0);
  assign win_no     = addr[ADDR_W-1:WIN_SHIFT];
  assign hit_enable = (addr == ADDR_W'(OFF_ENABLE));
  assign hit_status = (addr == ADDR_W'(OFF_STATUS));
  assign hit_sizing = (addr == ADDR_W'(OFF_SIZING));

  for (genvar g = 0; g < MB_SLOTS; g++) begin : g_win
    if (g < MB_COUNT) begin : g_built
      assign hit_mb[g] = low_clear && (win_no == HI_W'(g + FIRST_WIN));
    end else begin : g_absent
      assign hit_mb[g] = 1'b0;
    end
  end
endmodule

// File: rtl/shmbox_slot.sv
module shmbox_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst)
      word_q <= '0;
    else if (wr)
      word_q <= wdata;
  end
endmodule

// File: rtl/shmbox_irq.sv
module shmbox_irq
  import shmbox_pkg::*;
#(
  parameter int MB_COUNT = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en_wr,
  input  logic [31:0]           wdata,
  input  logic [MB_SLOTS-1:0]   full_vec,
  output logic [2*MB_SLOTS-1:0] en_q,
  output logic [2*MB_SLOTS-1:0] status,
  output logic                  irq_q
);
  localparam logic [MB_SLOTS-1:0]   BUILT  = built_mask(MB_COUNT);
  localparam logic [2*MB_SLOTS-1:0] EN_MSK = {BUILT, BUILT};

  assign status = {full_vec & BUILT, ~full_vec & BUILT};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_wr)
        en_q <= wdata[2*MB_SLOTS-1:0] & EN_MSK;
      irq_q <= |(status & en_q);
    end
  end
endmodule

// File: rtl/shmbox_bank.sv
module shmbox_bank
  import shmbox_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int MB_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  logic                  hit_enable, hit_status, hit_sizing;
  logic [MB_SLOTS-1:0]   hit_mb;
  logic [31:0]           mb_word [MB_SLOTS];
  logic [MB_SLOTS-1:0]   full_vec;
  logic [2*MB_SLOTS-1:0] irq_en;
  logic [2*MB_SLOTS-1:0] irq_status;
  logic [31:0]           rd_next;

  shmbox_decode #(.ADDR_W(ADDR_W), .MB_COUNT(MB_COUNT)) u_dec (
    .addr       (bus_addr),
    .hit_enable (hit_enable),
    .hit_status (hit_status),
    .hit_sizing (hit_sizing),
    .hit_mb     (hit_mb)
  );

  for (genvar g = 0; g < MB_SLOTS; g++) begin : g_mb
    if (g < MB_COUNT) begin : g_built
      shmbox_slot #(.DATA_W(32)) u_slot (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_we && hit_mb[g]),
        .wdata  (bus_wdata),
        .word_q (mb_word[g])
      );
    end else begin : g_absent
      assign mb_word[g] = '0;
    end
    assign full_vec[g] = mb_word[g][31];
  end

  shmbox_irq #(.MB_COUNT(MB_COUNT)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .en_wr    (bus_we && hit_enable),
    .wdata    (bus_wdata),
    .full_vec (full_vec),
    .en_q     (irq_en),
    .status   (irq_status),
    .irq_q    (irq_out)
  );

  always_comb begin
    rd_next = '0;
    if (hit_enable) rd_next = 32'(irq_en);
    if (hit_status) rd_next = 32'(irq_status);
    if (hit_sizing) rd_next = 32'(MB_COUNT) & 32'h0000_000f;
    for (int i = 0; i < MB_SLOTS; i++)
      if (hit_mb[i]) rd_next = rd_next | mb_word[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_re)
      bus_rdata <= rd_next;
  end
endmodule

// File: rtl/shmbox_bank_chk.sv
module shmbox_bank_chk
  import shmbox_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int MB_COUNT = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [31:0]           bus_wdata,
  input logic                  bus_we,
  input logic                  bus_re,
  input logic [31:0]           bus_rdata,
  input logic                  irq_out,
  input logic [MB_SLOTS-1:0]   full_vec,
  input logic [2*MB_SLOTS-1:0] irq_en,
  input logic [2*MB_SLOTS-1:0] irq_status
);
  a_r1_irq_low_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq_out);

  a_r6_irq_follows_enabled: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == $past(|(irq_status & irq_en))));

  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_re) |-> $stable(bus_rdata));

  for (genvar g = 0; g < MB_COUNT; g++) begin : g_mb
    a_r2_flag_set: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == ADDR_W'(mb_base(g)) && bus_wdata[31]) |=> full_vec[g]);
    a_r3_flag_clear: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == ADDR_W'(mb_base(g)) && !bus_wdata[31]) |=> !full_vec[g]);
  end
endmodule

bind shmbox_bank shmbox_bank_chk #(.ADDR_W(ADDR_W), .MB_COUNT(MB_COUNT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_rdata  (bus_rdata),
  .irq_out    (irq_out),
  .full_vec   (full_vec),
  .irq_en     (irq_en),
  .irq_status (irq_status)
);

// File: tb/sim_shmbox_bank.sv
module sim_shmbox_bank;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int MB_COUNT   = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic              bus_re = 1'b0;
  logic [31:0]       bus_rdata;
  logic              irq_out;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_mb [8];
  logic [15:0] m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  shmbox_bank #(.ADDR_W(ADDR_W), .MB_COUNT(MB_COUNT)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic logic [ADDR_W-1:0] mb_addr(input int i);
    return ADDR_W'(32'h10000 + 32'(i) * 32'h8000);
  endfunction

  function automatic logic [7:0] built();
    return 8'((1 << MB_COUNT) - 1);
  endfunction

  function automatic logic [15:0] exp_status();
    logic [7:0] f;
    for (int i = 0; i < 8; i++) f[i] = m_mb[i][31];
    return {f & built(), ~f & built()};
  endfunction

  function automatic logic exp_irq();
    return |(exp_status() & m_en);
  endfunction

  function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(32'h100)) return {16'b0, m_en};
    if (a == ADDR_W'(32'h304)) return {16'b0, exp_status()};
    if (a == ADDR_W'(32'h380)) return 32'(MB_COUNT);
    for (int i = 0; i < MB_COUNT; i++)
      if (a == mb_addr(i)) return m_mb[i];
    return 32'h0;
  endfunction

  function automatic void model_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    if (a == ADDR_W'(32'h100)) m_en = d[15:0] & {built(), built()};
    for (int i = 0; i < MB_COUNT; i++)
      if (a == mb_addr(i)) m_mb[i] = d;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check_read(input string tag, input logic [ADDR_W-1:0] a);
    logic [31:0] d;
    do_read(a, d);
    check(tag, d, exp_read(a));
  endtask

  task automatic check_irq(input string tag);
    @(posedge clk);
    @(negedge clk);
    check(tag, 32'(irq_out), 32'(exp_irq()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) m_mb[i] = '0;
    m_en = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq_out), 32'h0);
    for (int i = 0; i < MB_COUNT; i++) check_read("R1 mailbox", mb_addr(i));
    check_read("R1 enable", ADDR_W'(32'h100));
    do_read(ADDR_W'(32'h304), d);
    check("R1 status", d, 32'h0000_003f);

    // R7 sizing
    do_read(ADDR_W'(32'h380), d);
    check("R7 sizing", d, 32'd6);

    // R2 store with flag, R4 status
    do_write(mb_addr(2), 32'hdead_beef);
    check_read("R2 readback", mb_addr(2));
    do_read(ADDR_W'(32'h304), d);
    check("R4 status", d, 32'h0000_043b);

    // R3 free keeps message bits
    do_write(mb_addr(2), 32'h5a5a_1234);
    do_read(mb_addr(2), d);
    check("R3 freed", d, 32'h5a5a_1234);

    // R4 status write ignored
    do_write(ADDR_W'(32'h304), 32'hffff_ffff);
    check_read("R4 status ro", ADDR_W'(32'h304));

    // R5 enable masking, R6 irq from free conditions
    do_write(ADDR_W'(32'h100), 32'hffff_ffff);
    do_read(ADDR_W'(32'h100), d);
    check("R5 enable mask", d, 32'h0000_3f3f);
    check_irq("R6 irq free");

    // R6 holding only enable on mailbox 5
    do_write(ADDR_W'(32'h100), 32'h0000_2000);
    check_irq("R6 irq off");
    do_write(mb_addr(5), 32'h8000_0001);
    check("R6 not yet", 32'(irq_out), 32'h0);
    check_irq("R6 irq on");
    check_irq("R6 irq level");
    do_write(mb_addr(5), 32'h0000_0001);
    check_irq("R6 irq drop");

    // R8 absent mailbox and unmapped
    do_write(mb_addr(6), 32'hffff_ffff);
    do_read(mb_addr(6), d);
    check("R8 absent mb", d, 32'h0);
    do_write(ADDR_W'(32'h200), 32'h1234_5678);
    do_read(ADDR_W'(32'h200), d);
    check("R8 unmapped", d, 32'h0);
    do_read(mb_addr(0) + ADDR_W'(4), d);
    check("R8 window offset", d, 32'h0);
    check_read("R8 state kept", ADDR_W'(32'h304));
    check_read("R8 enable kept", ADDR_W'(32'h100));

    // R9 rdata holds without read enable
    do_read(mb_addr(2), d);
    repeat (3) @(negedge clk);
    check("R9 hold", bus_rdata, 32'h5a5a_1234);

    // R10 read during write returns old value
    bus_addr = mb_addr(1); bus_wdata = 32'h8765_4321; bus_we = 1'b1; bus_re = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    check("R10 old value", bus_rdata, m_mb[1]);
    model_write(mb_addr(1), 32'h8765_4321);
    check_read("R10 new value", mb_addr(1));

    // Random traffic: R2 R3 R4 R5 R6
    for (int it = 0; it < 400; it++) begin
      int op;
      int k;
      op = int'($urandom_range(0, 5));
      k  = int'($urandom_range(0, 7));
      case (op)
        0, 1: do_write(mb_addr(k), $urandom());
        2:    do_write(ADDR_W'(32'h100), $urandom());
        3:    check_read("R2 random mailbox", mb_addr(k));
        4:    check_read("R4 random status", ADDR_W'(32'h304));
        default: check_read("R5 random enable", ADDR_W'(32'h100));
      endcase
      check_irq("R6 random irq");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule